// File: doc/BRIEF.md
# Five-State Owner-Forwarding Coherence Cluster

This block keeps the coherence state of a group of private caches that share one snooped bus. Besides the usual invalid, shared, exclusive and modified states, each line can be held as Owned. A cache holding a line as Owned has the newest data while other caches keep read-only copies and memory is out of date. When a peer reads a line that some cache holds as Modified, that cache hands the data straight across, drops to Owned, and memory is not written. From then on only the Owned holder answers reads for that line. The dirty data returns to memory only when the Owned or Modified copy is evicted.

The bus carries one transaction per cycle. Whatever sits in front of the block decides which cache's core request (read, write or evict) goes on the bus in a cycle. The request names the cache, the operation and the line index. Every other cache snoops the bus command that the request produces. One cycle later the block reports the bus command issued and the requester's new state. It also reports whether a peer cache or memory supplies the data, whether a write-back is needed, and whether other holders existed. A state lookup port shows the state of any cache and line.

Top module: `moesi_cluster`

## Requirements
- R1: After reset every line of every cache reads as Invalid (code 0) on the lookup port, and `rsp_valid` is low.
- R2: A read that misses issues bus command 1 (read). The requester installs Exclusive (code 2) when no other cache holds the line and Shared (code 1) when one does, and `rsp_shared` shows which case applied. Memory supplies the data (`rsp_mem_fill`) unless a dirty holder does.
- R3: A snooped read on a Modified line makes that cache supply the data (`rsp_c2c` high, `rsp_supplier` its index) and move to Owned (code 3). The requester becomes Shared, and neither a write-back nor a memory fill takes place.
- R4: When a line has an Owned holder and Shared holders, only the Owned holder supplies data on a snooped read. An Exclusive holder that snoops a read moves to Shared without supplying.
- R5: A write to an Exclusive line moves it to Modified (code 4) with no bus command (code 0). A write to a Modified line also issues no bus command.
- R6: A write to a Shared or Owned line issues bus command 3 (invalidate). Every other holder goes Invalid and the requester goes Modified.
- R7: A write that misses issues bus command 2 (read for ownership). A Modified or Owned holder supplies the data and then goes Invalid, all other holders go Invalid, and the requester goes Modified.
- R8: Evicting a Modified or Owned line raises `rsp_wb` and leaves the line Invalid. Evicting a Shared, Exclusive or Invalid line raises no write-back and issues no bus command.
- R9: At no time do two caches hold the same line as Modified or Owned.
- R10: A read that hits issues no bus command and leaves the state unchanged.
- R11: While `req_valid` is low no state changes and `rsp_valid` stays low in the following cycle.
- R12: A transaction on one line index leaves the state of every other line index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A core request is on the bus this cycle |
| req_cache | input | CW | Index of the requesting cache |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_line | input | LW | Line index of the request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_bus_cmd | output | 2 | 0 none, 1 read, 2 read for ownership, 3 invalidate |
| rsp_new_state | output | 3 | Requester's new state: 0 I, 1 S, 2 E, 3 O, 4 M |
| rsp_c2c | output | 1 | A peer cache supplied the data |
| rsp_supplier | output | CW | Index of the supplying cache |
| rsp_mem_fill | output | 1 | Memory supplied the data |
| rsp_wb | output | 1 | Dirty data must be written back |
| rsp_shared | output | 1 | Other caches held the line when the bus command went out |
| peek_cache | input | CW | Cache selected on the lookup port |
| peek_line | input | LW | Line selected on the lookup port |
| peek_state | output | 3 | State of the selected line |

## Verification
The bench moves one line through a long chain of ownership changes. It checks the point where a Modified copy is read by a peer: a design that wrote back there, or that went to Shared instead of Owned, would show `rsp_wb` or a memory fill, or would lose its supplier on the next read. It reads a line that has both an Owned holder and a Shared holder, where a design that let Shared copies answer would report the wrong supplier, and it also covers the silent Exclusive-to-Shared drop. Evictions from both dirty states and from clean states check that write-backs appear only where memory is stale. After every step the bench scans all caches for a second dirty holder. It also checks that idle cycles and traffic on other line indices leave the state alone.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EV  = 2'd2,
    OP_NOP = 2'd3
  } core_op_t;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_INV  = 2'd3
  } bus_cmd_t;

  function automatic logic is_dirty(line_st_t st);
    return (st == ST_M) || (st == ST_O);
  endfunction

  // Bus command a requester places on the bus for its own operation
  function automatic bus_cmd_t bus_for_local(core_op_t op, line_st_t st);
    bus_cmd_t c;
    c = BUS_NONE;
    case (op)
      OP_RD: if (st == ST_I) c = BUS_RD;
      OP_WR: begin
        if (st == ST_I) c = BUS_RDX;
        else if (st == ST_S || st == ST_O) c = BUS_INV;
      end
      default: c = BUS_NONE;
    endcase
    return c;
  endfunction

  // Requester's next state; others_hold tells whether a peer kept a copy
  function automatic line_st_t next_local(core_op_t op, line_st_t st, logic others_hold);
    line_st_t n;
    n = st;
    case (op)
      OP_RD: if (st == ST_I) n = others_hold ? ST_S : ST_E;
      OP_WR: n = ST_M;
      OP_EV: n = ST_I;
      default: n = st;
    endcase
    return n;
  endfunction

  // Snooper's next state for a bus command issued by a peer
  function automatic line_st_t next_snoop(bus_cmd_t cmd, line_st_t st);
    line_st_t n;
    n = st;
    case (cmd)
      BUS_RD: begin
        if (st == ST_M) n = ST_O;
        else if (st == ST_E) n = ST_S;
      end
      BUS_RDX, BUS_INV: n = ST_I;
      default: n = st;
    endcase
    return n;
  endfunction

  function automatic logic snoop_supplies(bus_cmd_t cmd, line_st_t st);
    return ((cmd == BUS_RD) || (cmd == BUS_RDX)) && is_dirty(st);
  endfunction

  function automatic logic wb_needed(core_op_t op, line_st_t st);
    return (op == OP_EV) && is_dirty(st);
  endfunction

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  line_st_t      wr_st,
  input  logic [LW-1:0] rd_idx_a,
  output line_st_t      rd_st_a,
  input  logic [LW-1:0] rd_idx_b,
  output line_st_t      rd_st_b
);

  line_st_t lines_q [NLINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) lines_q[i] <= ST_I;
    end else if (wr_en) begin
      lines_q[wr_idx] <= wr_st;
    end
  end

  assign rd_st_a = lines_q[rd_idx_a];
  assign rd_st_b = lines_q[rd_idx_b];

endmodule

// File: rtl/moesi_cache_ctrl.sv
module moesi_cache_ctrl
  import moesi_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          is_req,
  input  core_op_t      req_op,
  input  bus_cmd_t      bus_cmd,
  input  logic [LW-1:0] bus_line,
  input  logic          others_hold,
  input  logic [LW-1:0] peek_line,
  output line_st_t      cur_st,
  output line_st_t      nxt_st,
  output line_st_t      peek_st,
  output logic          snp_hold,
  output logic          snp_supply
);

  logic wr_en;

  // Snoop side: named events for the cluster-level checks
  assign snp_hold   = !is_req && (cur_st != ST_I);
  assign snp_supply = bus_valid && !is_req && snoop_supplies(bus_cmd, cur_st);

  assign nxt_st = is_req ? next_local(req_op, cur_st, others_hold)
                         : next_snoop(bus_cmd, cur_st);
  assign wr_en  = bus_valid && (is_req || (bus_cmd != BUS_NONE));

  moesi_line_store #(.NLINES(NLINES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (bus_line),
    .wr_st    (nxt_st),
    .rd_idx_a (bus_line),
    .rd_st_a  (cur_st),
    .rd_idx_b (peek_line),
    .rd_st_b  (peek_st)
  );

endmodule

// File: rtl/moesi_resp_stage.sv
module moesi_resp_stage #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_valid,
  input  logic [1:0]    d_cmd,
  input  logic [2:0]    d_state,
  input  logic          d_c2c,
  input  logic [CW-1:0] d_sup,
  input  logic          d_mem,
  input  logic          d_wb,
  input  logic          d_sh,
  output logic          q_valid,
  output logic [1:0]    q_cmd,
  output logic [2:0]    q_state,
  output logic          q_c2c,
  output logic [CW-1:0] q_sup,
  output logic          q_mem,
  output logic          q_wb,
  output logic          q_sh
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_cmd   <= '0;
      q_state <= '0;
      q_c2c   <= 1'b0;
      q_sup   <= '0;
      q_mem   <= 1'b0;
      q_wb    <= 1'b0;
      q_sh    <= 1'b0;
    end else begin
      q_valid <= d_valid;
      q_cmd   <= d_cmd;
      q_state <= d_state;
      q_c2c   <= d_c2c;
      q_sup   <= d_sup;
      q_mem   <= d_mem;
      q_wb    <= d_wb;
      q_sh    <= d_sh;
    end
  end

endmodule

// File: rtl/moesi_cluster.sv
module moesi_cluster
  import moesi_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int NLINES = 8,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_cache,
  input  logic [1:0]    req_op,
  input  logic [LW-1:0] req_line,
  output logic          rsp_valid,
  output logic [1:0]    rsp_bus_cmd,
  output logic [2:0]    rsp_new_state,
  output logic          rsp_c2c,
  output logic [CW-1:0] rsp_supplier,
  output logic          rsp_mem_fill,
  output logic          rsp_wb,
  output logic          rsp_shared,
  input  logic [CW-1:0] peek_cache,
  input  logic [LW-1:0] peek_line,
  output logic [2:0]    peek_state
);

  core_op_t          op;
  line_st_t          cur_st  [NCACHE];
  line_st_t          nxt_st  [NCACHE];
  line_st_t          peek_st [NCACHE];
  logic [NCACHE-1:0] req_sel;
  logic [NCACHE-1:0] snp_hold;
  logic [NCACHE-1:0] snp_supply;
  logic [NCACHE-1:0] dirty_vec;
  line_st_t          req_cur;
  line_st_t          req_nxt;
  bus_cmd_t          bus_cmd;
  logic              others_hold;
  logic              c2c_now;
  logic [CW-1:0]     sup_now;
  logic              mem_now;
  logic              wb_now;
  logic              sh_now;

  assign op = core_op_t'(req_op);

  always_comb begin
    for (int i = 0; i < NCACHE; i++) req_sel[i] = req_valid && (req_cache == CW'(i));
  end

  // Requester's current and next state, picked from its controller
  always_comb begin
    req_cur = ST_I;
    req_nxt = ST_I;
    for (int i = 0; i < NCACHE; i++) begin
      if (req_sel[i]) begin
        req_cur = cur_st[i];
        req_nxt = nxt_st[i];
      end
    end
  end

  assign bus_cmd     = req_valid ? bus_for_local(op, req_cur) : BUS_NONE;
  assign others_hold = |snp_hold;
  assign c2c_now     = |snp_supply;
  assign mem_now     = ((bus_cmd == BUS_RD) || (bus_cmd == BUS_RDX)) && !c2c_now;
  assign wb_now      = req_valid && wb_needed(op, req_cur);
  assign sh_now      = (bus_cmd != BUS_NONE) && others_hold;

  always_comb begin
    sup_now = '0;
    for (int i = 0; i < NCACHE; i++) if (snp_supply[i]) sup_now = CW'(i);
  end

  always_comb begin
    for (int i = 0; i < NCACHE; i++) dirty_vec[i] = is_dirty(cur_st[i]);
  end

  for (genvar g = 0; g < NCACHE; g++) begin : g_cache
    moesi_cache_ctrl #(.NLINES(NLINES)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid   (req_valid),
      .is_req      (req_sel[g]),
      .req_op      (op),
      .bus_cmd     (bus_cmd),
      .bus_line    (req_line),
      .others_hold (others_hold),
      .peek_line   (peek_line),
      .cur_st      (cur_st[g]),
      .nxt_st      (nxt_st[g]),
      .peek_st     (peek_st[g]),
      .snp_hold    (snp_hold[g]),
      .snp_supply  (snp_supply[g])
    );
  end

  always_comb begin
    peek_state = 3'(ST_I);
    for (int i = 0; i < NCACHE; i++) if (peek_cache == CW'(i)) peek_state = 3'(peek_st[i]);
  end

  moesi_resp_stage #(.CW(CW)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (req_valid),
    .d_cmd   (2'(bus_cmd)),
    .d_state (3'(req_nxt)),
    .d_c2c   (c2c_now),
    .d_sup   (sup_now),
    .d_mem   (mem_now),
    .d_wb    (wb_now),
    .d_sh    (sh_now),
    .q_valid (rsp_valid),
    .q_cmd   (rsp_bus_cmd),
    .q_state (rsp_new_state),
    .q_c2c   (rsp_c2c),
    .q_sup   (rsp_supplier),
    .q_mem   (rsp_mem_fill),
    .q_wb    (rsp_wb),
    .q_sh    (rsp_shared)
  );

  AST_SINGLE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dirty_vec) <= 1); // R9
  AST_ONE_SUPPLIER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snp_supply)); // R4
  AST_C2C_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_c2c) |-> (!rsp_wb && !rsp_mem_fill)); // R3
  AST_DIRTY_EVICT_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_EV && is_dirty(req_cur)) |=> (rsp_wb && rsp_new_state == 3'(ST_I))); // R8
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_RD && req_cur != ST_I) |=> (rsp_bus_cmd == 2'(BUS_NONE))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R11

endmodule

// File: tb/moesi_cluster_tb.sv
module moesi_cluster_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_cache = '0;
  logic [1:0] req_op = '0;
  logic [2:0] req_line = '0;
  logic       rsp_valid;
  logic [1:0] rsp_bus_cmd;
  logic [2:0] rsp_new_state;
  logic       rsp_c2c;
  logic [1:0] rsp_supplier;
  logic       rsp_mem_fill;
  logic       rsp_wb;
  logic       rsp_shared;
  logic [1:0] peek_cache = '0;
  logic [2:0] peek_line = '0;
  logic [2:0] peek_state;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  moesi_cluster #(.NCACHE(4), .NLINES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cache(req_cache),
    .req_op(req_op), .req_line(req_line), .rsp_valid(rsp_valid),
    .rsp_bus_cmd(rsp_bus_cmd), .rsp_new_state(rsp_new_state), .rsp_c2c(rsp_c2c),
    .rsp_supplier(rsp_supplier), .rsp_mem_fill(rsp_mem_fill), .rsp_wb(rsp_wb),
    .rsp_shared(rsp_shared), .peek_cache(peek_cache), .peek_line(peek_line),
    .peek_state(peek_state)
  );

  // Row: cache, op, line, cmd, new state, c2c, supplier, mem, wb, shared, peek cache, peek state
  localparam int NROWS = 17;
  localparam logic [22:0] ROWS [NROWS] = '{
    {2'd0, 2'd0, 3'd0, 2'd1, 3'd2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 3'd2},
    {2'd0, 2'd1, 3'd0, 2'd0, 3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd4},
    {2'd1, 2'd0, 3'd0, 2'd1, 3'd1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd3},
    {2'd2, 2'd0, 3'd0, 2'd1, 3'd1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 3'd1},
    {2'd1, 2'd0, 3'd0, 2'd0, 3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3},
    {2'd2, 2'd1, 3'd0, 2'd3, 3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0},
    {2'd0, 2'd0, 3'd0, 2'd1, 3'd1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, 3'd3},
    {2'd3, 2'd1, 3'd0, 2'd2, 3'd4, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, 3'd0},
    {2'd3, 2'd2, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 3'd0},
    {2'd1, 2'd1, 3'd0, 2'd2, 3'd4, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 3'd4},
    {2'd2, 2'd0, 3'd0, 2'd1, 3'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 2'd1, 3'd3},
    {2'd1, 2'd2, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 3'd0},
    {2'd2, 2'd2, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 3'd0},
    {2'd3, 2'd0, 3'd0, 2'd1, 3'd2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd3, 3'd2},
    {2'd0, 2'd0, 3'd0, 2'd1, 3'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 2'd3, 3'd1},
    {2'd0, 2'd1, 3'd0, 2'd3, 3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd3, 3'd0},
    {2'd1, 2'd2, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0}
  };

  function automatic string row_tag(int r);
    case (r)
      0, 13: return "R2";
      1: return "R5";
      2: return "R3";
      3, 14: return "R4";
      4: return "R10";
      5, 15: return "R6";
      6: return "R3";
      7, 9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [1:0] o, input logic [2:0] l);
    @(negedge clk);
    req_cache = c; req_op = o; req_line = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic peek(input logic [1:0] c, input logic [2:0] l, output int st);
    peek_cache = c; peek_line = l;
    #1;
    st = int'(peek_state);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int st;
    int dirty_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 8; l++) begin
        peek(2'(c), 3'(l), st);
        chk("R1 state", st, 0);
      end
    end

    // Table walk on line 0
    for (int r = 0; r < NROWS; r++) begin
      logic [22:0] v;
      v = ROWS[r];
      step(v[22:21], v[20:19], v[18:16]);
      chk({row_tag(r), " valid"}, int'(rsp_valid), 1);
      chk({row_tag(r), " cmd"}, int'(rsp_bus_cmd), int'(v[15:14]));
      chk({row_tag(r), " state"}, int'(rsp_new_state), int'(v[13:11]));
      chk({row_tag(r), " c2c"}, int'(rsp_c2c), int'(v[10]));
      if (v[10]) chk({row_tag(r), " supplier"}, int'(rsp_supplier), int'(v[9:8]));
      chk({row_tag(r), " mem"}, int'(rsp_mem_fill), int'(v[7]));
      chk({row_tag(r), " wb"}, int'(rsp_wb), int'(v[6]));
      chk({row_tag(r), " shared"}, int'(rsp_shared), int'(v[5]));
      peek(v[4:3], v[18:16], st);
      chk({row_tag(r), " peer state"}, st, int'(v[2:0]));
      // R9: never two dirty holders
      dirty_cnt = 0;
      for (int c = 0; c < 4; c++) begin
        peek(2'(c), v[18:16], st);
        if (st == 3 || st == 4) dirty_cnt++;
      end
      chk("R9 dirty holders", (dirty_cnt <= 1) ? 1 : 0, 1);
    end

    // R12: traffic on line 5 leaves line 0 alone
    step(2'd2, 2'd0, 3'd5);
    chk("R12 l5 state", int'(rsp_new_state), 2);
    chk("R12 l5 mem", int'(rsp_mem_fill), 1);
    step(2'd2, 2'd1, 3'd5);
    chk("R5 l5 silent", int'(rsp_bus_cmd), 0);
    peek(2'd0, 3'd0, st);
    chk("R12 c0 l0", st, 4);
    peek(2'd2, 3'd0, st);
    chk("R12 c2 l0", st, 0);
    peek(2'd2, 3'd5, st);
    chk("R12 c2 l5", st, 4);

    // R11: request fields present but not valid
    @(negedge clk);
    req_cache = 2'd1; req_op = 2'd1; req_line = 3'd0; req_valid = 1'b0;
    @(negedge clk);
    chk("R11 rsp_valid", int'(rsp_valid), 0);
    peek(2'd1, 3'd0, st);
    chk("R11 c1 l0", st, 0);
    peek(2'd0, 3'd0, st);
    chk("R11 c0 l0", st, 4);

    summary();
    $finish;
  end

endmodule